// File: doc/BRIEF.md
# EDO DRAM Controller with CBR Refresh

This block lets a synchronous host reach an asynchronous 4M x 4 extended-data-out DRAM. The host hands over one request at a time through a valid/ready handshake: a 22-bit word address, a write flag and a 4-bit write value. For a read, the block returns the 4-bit read value with a one-cycle valid strobe. On the memory side the block drives the multiplexed address pins, the four active-low strobes and a 4-bit data bus that is split into input, output and output-enable.

After an access the row stays open. A later request to the same row runs as a hyper-page column cycle with no new row strobe. A request to a different row closes the page, waits out precharge and opens the new row. A free-running timer requests a CAS-before-RAS refresh about every 15.6 us, which is the interval that fits both refresh options. A pending refresh outranks new host work. After reset the block runs eight refresh cycles before it accepts its first request. All analog timings are given as cycle counts in parameters, and a parameter selects the 4K or 2K row/column split.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is applied, RAS#, CAS#, WE# and OE# are high, the data bus output-enable is low, and the host ready signal is low.
- R2: After reset is released, exactly eight CBR refresh cycles take place before the host ready signal first rises. No row is opened for an access before that point.
- R3: With the 4K option, the row pins carry host address bits 21..10 on pins 11..0 when RAS# falls for an access. The column pins carry bits 9..0 on pins 9..0 when CAS# falls, and pins 11..10 are zero. With the 2K option, the row is bits 21..11 and the column is bits 10..0, both on pins 10..0.
- R4: A read returns the value stored at the addressed location on the read data port, together with a single-cycle valid pulse. The pulse coincides with CAS# rising, and the data is sampled no earlier than RAC_CYC cycles after RAS# fell and CAC_CYC cycles after CAS# fell.
- R5: A write is an early write. WE# is already low in the cycle before CAS# falls, the data bus is driven while CAS# is low, and OE# stays high.
- R6: A request to the row that is already open is served with a new CAS# cycle and no RAS# cycle. Consecutive CAS# falls within one open row are at least HPC_CYC cycles apart.
- R7: Successive RAS# falls are at least RC_CYC cycles apart, and RAS# falls no sooner than RP_CYC cycles after it last rose.
- R8: Refresh is CAS-before-RAS. CAS# falls while RAS# is high and stays low through RAS# falling. With an idle host, refresh cycles are spaced REF_INTERVAL cycles apart, where REF_INTERVAL = CLK_MHZ*15625/1000.
- R9: A refresh that is due takes precedence over new host requests. The open page is closed by raising RAS# before the refresh, so a host that keeps hitting one open row cannot postpone refresh.
- R10: The host ready signal is low during a refresh cycle and while fewer than RP_CYC cycles have passed since RAS# last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_addr | input | 22 | Host word address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write value |
| rsp_valid | output | 1 | Read value valid pulse |
| rsp_rdata | output | 4 | Read value |
| mem_addr | output | 12 | Multiplexed row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_in | input | 4 | Data from the memory |
| mem_dq_out | output | 4 | Data to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The hardest case to reach is a refresh tick that lands while the host keeps a page busy. Only that case shows whether refresh can be starved or whether the page is closed correctly first. The bench reaches it by issuing same-row reads back to back with no gap until the memory model's refresh counter moves. To prove that hyper-page reuse happens at all, the bench first waits for a refresh so that the page is known to be closed, then counts RAS# falls across two same-row reads. A behavioural memory with its own nanosecond timing checks returns inverted data for any read sampled too early.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int HOST_AW = 22;
  localparam int DQ_W    = 4;
  localparam int PIN_W   = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_OPEN,
    ST_REFC,
    ST_REFR
  } edo_state_e;

  typedef struct packed {
    logic               wr;
    logic [HOST_AW-1:0] addr;
    logic [DQ_W-1:0]    wdata;
  } edo_req_t;
endpackage

// File: rtl/edo_age_ctr.sv
// Saturating count of cycles since the last start pulse; saturated out of reset.
module edo_age_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] age
);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  logic [CNT_W-1:0] age_d;

  always_comb begin
    if (start)               age_d = CNT_W'(1);
    else if (age != AGE_MAX) age_d = age + CNT_W'(1);
    else                     age_d = age;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= AGE_MAX;
    else        age <= age_d;
  end
endmodule

// File: rtl/edo_ref_timer.sv
// Refresh interval timer, pending flag and power-up refresh burst.
module edo_ref_timer #(
  parameter int INTERVAL  = 3125,
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic ref_need,
  output logic init_busy
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int IW = $clog2(INIT_REFS + 1);

  logic [TW-1:0] tick_cnt, tick_cnt_d;
  logic [IW-1:0] init_left, init_left_d;
  logic          due, due_d, tick;

  assign tick      = (tick_cnt == '0);
  assign init_busy = (init_left != '0);
  assign ref_need  = due | init_busy;

  always_comb begin
    tick_cnt_d  = tick ? TW'(INTERVAL - 1) : tick_cnt - TW'(1);
    init_left_d = init_left;
    due_d       = due;
    if (ref_done) begin
      if (init_busy) init_left_d = init_left - IW'(1);
      else           due_d       = 1'b0;
    end
    if (tick) due_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt  <= TW'(INTERVAL - 1);
      init_left <= IW'(INIT_REFS);
      due       <= 1'b0;
    end else begin
      tick_cnt  <= tick_cnt_d;
      init_left <= init_left_d;
      due       <= due_d;
    end
  end
endmodule

// File: rtl/edo_addr_map.sv
// Splits a host word address into row and column pin values.
module edo_addr_map
  import edo_pkg::*;
#(
  parameter bit ROW4K = 1'b1
) (
  input  logic [HOST_AW-1:0] addr,
  output logic [PIN_W-1:0]   row_pins,
  output logic [PIN_W-1:0]   col_pins
);
  generate
    if (ROW4K) begin : g_4k
      assign row_pins = addr[21:10];
      assign col_pins = {2'b00, addr[9:0]};
    end else begin : g_2k
      assign row_pins = {1'b0, addr[21:11]};
      assign col_pins = {1'b0, addr[10:0]};
    end
  endgenerate
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter bit ROW4K     = 1'b1,
  parameter int CLK_MHZ   = 200,
  parameter int RC_CYC    = 17,
  parameter int RP_CYC    = 6,
  parameter int RCD_CYC   = 4,
  parameter int RAC_CYC   = 10,
  parameter int CAC_CYC   = 3,
  parameter int HPC_CYC   = 4,
  parameter int CSR_CYC   = 2,
  parameter int RAS_CYC   = 10,
  parameter int INIT_REFS = 8,
  parameter int CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [21:0]        req_addr,
  input  logic               req_wr,
  input  logic [3:0]         req_wdata,
  output logic               rsp_valid,
  output logic [3:0]         rsp_rdata,
  output logic [11:0]        mem_addr,
  output logic               mem_ras_n,
  output logic               mem_cas_n,
  output logic               mem_we_n,
  output logic               mem_oe_n,
  input  logic [3:0]         mem_dq_in,
  output logic [3:0]         mem_dq_out,
  output logic               mem_dq_oe
);
  localparam int REF_INTERVAL = CLK_MHZ * 15625 / 1000;
  localparam int ROW_W        = ROW4K ? 12 : 11;
  localparam logic [CNT_W-1:0] T_RC  = CNT_W'(RC_CYC);
  localparam logic [CNT_W-1:0] T_RP  = CNT_W'(RP_CYC);
  localparam logic [CNT_W-1:0] T_RCD = CNT_W'(RCD_CYC);
  localparam logic [CNT_W-1:0] T_RAC = CNT_W'(RAC_CYC);
  localparam logic [CNT_W-1:0] T_CAC = CNT_W'(CAC_CYC);
  localparam logic [CNT_W-1:0] T_HPC = CNT_W'(HPC_CYC);
  localparam logic [CNT_W-1:0] T_CSR = CNT_W'(CSR_CYC);
  localparam logic [CNT_W-1:0] T_RAS = CNT_W'(RAS_CYC);

  // reset: asynchronous assertion, synchronous release
  logic rs_meta, rs_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  edo_state_e       st_q, st_d;
  edo_req_t         cur_q, cur_d, new_req;
  logic             held_q, held_d;
  logic             ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic             ras_n_d, cas_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [PIN_W-1:0] addr_q, addr_d, row_pins, col_pins;
  logic [3:0]       rdata_q, rdata_d;
  logic             rvalid_q, cap;
  logic             ref_need, init_busy, ref_done;
  logic [CNT_W-1:0] ras_age, rp_age, cas_age;
  logic             ras_fall, ras_rise, cas_fall;
  logic             timing_ok, same_row, ready;

  assign new_req = '{wr: req_wr, addr: req_addr, wdata: req_wdata};

  edo_ref_timer #(.INTERVAL(REF_INTERVAL), .INIT_REFS(INIT_REFS)) u_timer (
    .clk(clk), .rst_n(rs_sync), .ref_done(ref_done),
    .ref_need(ref_need), .init_busy(init_busy)
  );

  edo_addr_map #(.ROW4K(ROW4K)) u_map (
    .addr(cur_d.addr), .row_pins(row_pins), .col_pins(col_pins)
  );

  assign ras_fall = !ras_n_d &&  ras_n_q;
  assign ras_rise =  ras_n_d && !ras_n_q;
  assign cas_fall = !cas_n_d &&  cas_n_q;

  edo_age_ctr #(.CNT_W(CNT_W)) u_ras_age (.clk(clk), .rst_n(rs_sync), .start(ras_fall), .age(ras_age));
  edo_age_ctr #(.CNT_W(CNT_W)) u_rp_age  (.clk(clk), .rst_n(rs_sync), .start(ras_rise), .age(rp_age));
  edo_age_ctr #(.CNT_W(CNT_W)) u_cas_age (.clk(clk), .rst_n(rs_sync), .start(cas_fall), .age(cas_age));

  assign timing_ok = (ras_age >= T_RC) && (rp_age >= T_RP);
  assign same_row  = (req_addr[HOST_AW-1 -: ROW_W] == cur_q.addr[HOST_AW-1 -: ROW_W]);

  always_comb begin
    ready = 1'b0;
    if (st_q == ST_IDLE)
      ready = !ref_need && !held_q && timing_ok;
    else if (st_q == ST_OPEN)
      ready = !ref_need && (cas_age >= T_HPC - CNT_W'(1)) && (ras_age >= T_RAS);
  end

  // next-state process
  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    held_d   = held_q;
    cap      = 1'b0;
    ref_done = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ref_need && timing_ok) st_d = ST_REFC;
        else if (held_q && timing_ok) begin
          st_d   = ST_RCD;
          held_d = 1'b0;
        end else if (req_valid && ready) begin
          cur_d = new_req;
          st_d  = ST_RCD;
        end
      end
      ST_RCD:  if (ras_age >= T_RCD) st_d = ST_COL;
      ST_COL:  st_d = ST_CAS;
      ST_CAS: begin
        if ((cas_age >= T_CAC) && (cur_q.wr || ras_age >= T_RAC)) begin
          st_d = ST_OPEN;
          cap  = !cur_q.wr;
        end
      end
      ST_OPEN: begin
        if (ref_need) begin
          if (ras_age >= T_RAS) st_d = ST_IDLE;
        end else if (req_valid && ready) begin
          cur_d = new_req;
          if (same_row) st_d = ST_COL;
          else begin
            st_d   = ST_IDLE;
            held_d = 1'b1;
          end
        end
      end
      ST_REFC: if (cas_age >= T_CSR) st_d = ST_REFR;
      ST_REFR: begin
        if (ras_age >= T_RAS) begin
          st_d     = ST_IDLE;
          ref_done = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // pin values follow the next state so that every pin is a flop output
  always_comb begin
    ras_n_d = !(st_d inside {ST_RCD, ST_COL, ST_CAS, ST_OPEN, ST_REFR});
    cas_n_d = !(st_d inside {ST_CAS, ST_REFC, ST_REFR});
    we_n_d  = !((st_d inside {ST_COL, ST_CAS}) && cur_d.wr);
    oe_n_d  = !((st_d == ST_CAS) && !cur_d.wr);
    dq_oe_d = (st_d inside {ST_COL, ST_CAS}) && cur_d.wr;
    if (st_d == ST_RCD)                      addr_d = row_pins;
    else if (st_d inside {ST_COL, ST_CAS})   addr_d = col_pins;
    else                                     addr_d = '0;
    rdata_d = cap ? mem_dq_in : rdata_q;
  end

  // register process
  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      held_q   <= 1'b0;
      ras_n_q  <= 1'b1;
      cas_n_q  <= 1'b1;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      addr_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      held_q   <= held_d;
      ras_n_q  <= ras_n_d;
      cas_n_q  <= cas_n_d;
      we_n_q   <= we_n_d;
      oe_n_q   <= oe_n_d;
      dq_oe_q  <= dq_oe_d;
      addr_q   <= addr_d;
      rdata_q  <= rdata_d;
      rvalid_q <= cap;
    end
  end

  assign req_ready  = ready;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ras_n  = ras_n_q;
  assign mem_cas_n  = cas_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_out = cur_q.wdata;
  assign mem_dq_oe  = dq_oe_q;

  // ---------------- assertions ----------------
  p_init_hold_r2: assert property (@(posedge clk) disable iff (!rs_sync)
    init_busy |-> !req_ready);

  p_rvalid_edge_r4: assert property (@(posedge clk) disable iff (!rs_sync)
    rsp_valid |-> ($rose(mem_cas_n) && !mem_ras_n));

  p_early_write_r5: assert property (@(posedge clk) disable iff (!rs_sync)
    ($fell(mem_cas_n) && !mem_we_n) |-> ($past(!mem_we_n) && mem_dq_oe && mem_oe_n));

  p_page_spacing_r6: assert property (@(posedge clk) disable iff (!rs_sync)
    (cas_fall && !ras_n_q) |-> (cas_age >= T_HPC));

  p_row_cycle_r7: assert property (@(posedge clk) disable iff (!rs_sync)
    ras_fall |-> ((ras_age >= T_RC) && (rp_age >= T_RP)));

  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rs_sync)
    ($fell(mem_ras_n) && !mem_cas_n) |-> $past(!mem_cas_n));

  p_busy_ready_r10: assert property (@(posedge clk) disable iff (!rs_sync)
    (st_q inside {ST_REFC, ST_REFR}) |-> !req_ready);

  p_bus_exclusive_r5: assert property (@(posedge clk) disable iff (!rs_sync)
    mem_dq_oe |-> mem_oe_n);
endmodule

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps

module edo_dram_model #(
  parameter int  ROW_W  = 12,
  parameter int  COL_W  = 10,
  parameter real T_RC   = 84.0,
  parameter real T_RP   = 30.0,
  parameter real T_HPC  = 20.0,
  parameter real T_RAC  = 50.0,
  parameter real T_CAC  = 15.0,
  parameter real T_HALF = 2.5
) (
  input  logic        clk,
  input  logic [11:0] addr,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [3:0]  dq_drv,
  input  logic        dq_en,
  output logic [3:0]  dq_rd
);
  logic [3:0] mem [int unsigned];
  logic [ROW_W-1:0] row = '0;
  logic [COL_W-1:0] col = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic in_ref = 1'b0, cas_in_row = 1'b0;
  realtime t_rf = -1000.0, t_rr = -1000.0, t_cf = -1000.0, t_ref = 0.0;
  int ref_cnt = 0, acc_cnt = 0, cas_cnt = 0, viol = 0;

  initial dq_rd = 4'h0;

  always @(negedge clk) begin
    realtime te, ts;
    logic [ROW_W+COL_W-1:0] key;
    logic [3:0] d;
    te = $realtime - T_HALF;
    ts = $realtime + T_HALF;
    if (prev_ras && !ras_n) begin
      if (te - t_rf < T_RC) begin viol++; $display("model: row cycle too short at %0t", $realtime); end
      if (te - t_rr < T_RP) begin viol++; $display("model: precharge too short at %0t", $realtime); end
      t_rf = te;
      cas_in_row = 1'b0;
      if (!cas_n) begin
        if (!in_ref) viol++;
        ref_cnt++;
        t_ref = te;
      end else begin
        acc_cnt++;
        row = addr[ROW_W-1:0];
      end
    end
    if (!prev_ras && ras_n) begin
      t_rr = te;
      in_ref = 1'b0;
    end
    if (prev_cas && !cas_n) begin
      if (ras_n) in_ref = 1'b1;
      else begin
        if (cas_in_row && (te - t_cf < T_HPC)) begin viol++; $display("model: page cycle too short at %0t", $realtime); end
        cas_in_row = 1'b1;
        col = addr[COL_W-1:0];
        cas_cnt++;
        if (!we_n) begin
          if (prev_we || !dq_en || !oe_n) begin viol++; $display("model: write strobe order at %0t", $realtime); end
          key = {row, col};
          mem[int'(key)] = dq_drv;
        end
      end
      t_cf = te;
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
    prev_we  = we_n;
    if (!ras_n && !cas_n && !oe_n && we_n && !in_ref) begin
      key = {row, col};
      d = mem.exists(int'(key)) ? mem[int'(key)] : (key[3:0] ^ 4'h5);
      if ((ts - t_rf >= T_RAC) && (ts - t_cf >= T_CAC)) dq_rd = d;
      else dq_rd = ~d;
    end else dq_rd = 4'h0;
  end
endmodule

module edo_dram_ctrl_tb;
  localparam int REF_INT = 200 * 15625 / 1000;
  localparam int RP_CYC  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wr = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [11:0] mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0]  mem_dq_in, mem_dq_out;

  int total = 0, bad = 0;
  int ready_bad = 0;
  int rise_age = 1000;
  logic prev_ras_tb = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edo_dram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wr(req_wr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  edo_dram_model u_mem (
    .clk(clk), .addr(mem_addr), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_drv(mem_dq_out), .dq_en(mem_dq_oe),
    .dq_rd(mem_dq_in)
  );

  // R10 monitor: ready must stay low in refresh and during precharge
  always @(negedge clk) begin
    if (prev_ras_tb == 1'b0 && mem_ras_n == 1'b1) rise_age = 1;
    else if (rise_age < 1000) rise_age++;
    prev_ras_tb = mem_ras_n;
    if (rst_n && req_ready && (u_mem.in_ref || (mem_ras_n && rise_age < RP_CYC)))
      ready_bad++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issues one request; for a read, returns the value seen with rsp_valid
  task automatic access(input bit wr, input logic [21:0] a, input logic [3:0] wd,
                        output logic [3:0] rd);
    int c0;
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    c0 = u_mem.cas_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    rd = 4'h0;
    if (wr) begin
      while (u_mem.cas_cnt == c0) @(negedge clk);
      @(negedge clk);
    end else begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
  endtask

  // {wr, addr[21:0], wdata, expected read value}
  localparam logic [30:0] VEC [13] = '{
    {1'b1, 22'h012345, 4'h9, 4'h0},
    {1'b1, 22'h012346, 4'h6, 4'h0},
    {1'b0, 22'h012345, 4'h0, 4'h9},
    {1'b0, 22'h012346, 4'h0, 4'h6},
    {1'b1, 22'h3FFFFF, 4'hF, 4'h0},
    {1'b0, 22'h3FFFFF, 4'h0, 4'hF},
    {1'b1, 22'h000000, 4'h3, 4'h0},
    {1'b0, 22'h012345, 4'h0, 4'h9},
    {1'b0, 22'h000000, 4'h0, 4'h3},
    {1'b0, 22'h2AA155, 4'h0, 4'h0},
    {1'b1, 22'h2AA155, 4'hA, 4'h0},
    {1'b0, 22'h2AA155, 4'h0, 4'hA},
    {1'b0, 22'h012346, 4'h0, 4'h6}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd;
    int r0, a0, c0, n;
    realtime t1, t2;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} == 4'hF, "R1 strobes", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
    chk(mem_dq_oe == 1'b0, "R1 bus", mem_dq_oe, 0);
    chk(req_ready == 1'b0, "R1 ready", req_ready, 0);
    rst_n = 1'b1;

    // R2: eight refreshes before first ready
    while (!req_ready) @(negedge clk);
    chk(u_mem.ref_cnt == 8, "R2 init refreshes", u_mem.ref_cnt, 8);
    chk(u_mem.acc_cnt == 0, "R2 no access", u_mem.acc_cnt, 0);

    // table walk: R3 address split, R4 read data, R5 writes
    foreach (VEC[i]) begin
      access(VEC[i][30], VEC[i][29:8], VEC[i][7:4], rd);
      chk(u_mem.row == VEC[i][29:18], "R3 row", u_mem.row, VEC[i][29:18]);
      chk(u_mem.col == VEC[i][17:8], "R3 col", u_mem.col, VEC[i][17:8]);
      if (!VEC[i][30]) chk(rd == VEC[i][3:0], "R4 read", rd, VEC[i][3:0]);
    end

    // R6: same-row reuse right after a refresh closed the page
    r0 = u_mem.ref_cnt;
    while (u_mem.ref_cnt == r0) @(negedge clk);
    a0 = u_mem.acc_cnt; c0 = u_mem.cas_cnt;
    access(1'b0, 22'h012345, 4'h0, rd);
    chk(rd == 4'h9, "R6 first read", rd, 4'h9);
    access(1'b0, 22'h012346, 4'h0, rd);
    chk(rd == 4'h6, "R6 page read", rd, 4'h6);
    access(1'b1, 22'h012347, 4'hC, rd);
    access(1'b0, 22'h012347, 4'h0, rd);
    chk(rd == 4'hC, "R6 page write-read", rd, 4'hC);
    chk(u_mem.acc_cnt - a0 == 1, "R6 single row open", u_mem.acc_cnt - a0, 1);
    chk(u_mem.cas_cnt - c0 == 4, "R6 column cycles", u_mem.cas_cnt - c0, 4);

    // R9: continuous same-row traffic must not starve refresh
    r0 = u_mem.ref_cnt;
    n = 0;
    while (u_mem.ref_cnt == r0 && n < 900) begin
      access(1'b0, 22'h012346, 4'h0, rd);
      n++;
    end
    chk(u_mem.ref_cnt > r0, "R9 refresh under load", u_mem.ref_cnt - r0, 1);
    access(1'b0, 22'h012346, 4'h0, rd);
    chk(rd == 4'h6, "R9 data after refresh", rd, 4'h6);

    // R8: refresh spacing with an idle host
    r0 = u_mem.ref_cnt;
    while (u_mem.ref_cnt == r0) @(negedge clk);
    r0 = u_mem.ref_cnt;
    while (u_mem.ref_cnt == r0) @(negedge clk);
    t1 = u_mem.t_ref;
    r0 = u_mem.ref_cnt;
    while (u_mem.ref_cnt == r0) @(negedge clk);
    t2 = u_mem.t_ref;
    n = int'((t2 - t1) / 5.0);
    chk(n >= REF_INT - 2 && n <= REF_INT + 2, "R8 interval", n, REF_INT);

    // R7 (and R5/R6/R8 spacing and ordering) from the memory model's checks
    chk(u_mem.viol == 0, "R7 timing violations", u_mem.viol, 0);
    // R10
    chk(ready_bad == 0, "R10 ready while busy", ready_bad, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule